// File: doc/BRIEF.md
# Character-Clocked Horizontal Timing Generator

This block produces the horizontal timing of a character-based raster display controller from a single master pixel clock. Three clock enables are stacked: the master clock yields a dot enable (full or half rate), the dot enable yields a character enable every 8 or 9 dots, and the character enable advances a video memory refresh address, either every character or every second character. A character counter drives a display-enable flag and restarts each line after a programmable total.

The refresh address of each new line is the previous line's first address plus a separate line-step value. A frame can therefore be wider in memory than on screen. An external frame-start strobe restarts the line and reloads the first address. All configuration inputs are captured only at a line start, so software may change them at any time without tearing the current line.

Top module: `char_htiming`

## Requirements
- R1: With `cfg_dot_half` = 0, `dot_en` is high on every master clock. With it at 1, `dot_en` is high on every second master clock, and a line holds (total+1)×dots-per-character dot enables.
- R2: `char_en` is high on the last dot of each character. A character is 8 dots with `cfg_nine_dot` = 0 and 9 dots with it at 1. Each line has `cfg_total`+1 characters.
- R3: `disp_en` is high from character 0 through character `cfg_disp_end` inclusive, which gives (`cfg_disp_end`+1)×dots-per-character×(1 or 2) master clocks per line. A setting of 79 gives 640 or 720 visible dots.
- R4: A line lasts `cfg_total`+1 characters. After that the character counter returns to 0, and it never exceeds `cfg_total`.
- R5: `line_start` is high for exactly one master clock, on the first dot enable of each line.
- R6: With `cfg_addr_half` = 0, `mem_addr` at character k of a line equals the line's first address plus min(k, `cfg_disp_end`+1). It holds during blanking.
- R7: With `cfg_addr_half` = 1, `mem_addr` advances on every second displayed character: character k shows the first address plus floor(min(k, `cfg_disp_end`+1)/2).
- R8: The first address of each line equals the previous line's first address plus `cfg_line_step`, modulo 2^ADDR_W.
- R9: `pad_dot` marks the ninth dot of each character in 9-dot mode, which is the one position that carries no fetched data. It is never high in 8-dot mode.
- R10: A `frame_start` pulse makes the next master clock the first dot of a new line, with `line_start` high and `mem_addr` equal to `cfg_start_addr`.
- R11: Configuration inputs are captured only at a line start (line wrap, frame start or reset). A change made during a line takes effect from the next line.
- R12: While `rst_n` is low, `mem_addr` equals `cfg_start_addr`, `line_start` and `disp_en` are high, and `char_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Restart line and reload start address |
| cfg_dot_half | input | 1 | 1: dot enable at half master rate |
| cfg_nine_dot | input | 1 | 1: 9 dots per character, 0: 8 |
| cfg_disp_end | input | CNT_W | Displayed characters minus one |
| cfg_total | input | CNT_W | Characters per line minus one |
| cfg_addr_half | input | 1 | 1: address advances every second character |
| cfg_line_step | input | OFS_W | Address increment between lines |
| cfg_start_addr | input | ADDR_W | First address of a frame |
| dot_en | output | 1 | Dot clock enable |
| char_en | output | 1 | Character clock enable (last dot of a character) |
| disp_en | output | 1 | Horizontal display enable |
| line_start | output | 1 | First dot of a line |
| pad_dot | output | 1 | Ninth, unfetched dot position |
| mem_addr | output | ADDR_W | Current refresh address |

## Verification
The bench uses the default parameters (CNT_W = 8, ADDR_W = 16, OFS_W = 8) but programs short lines of 10 to 12 characters. Each of the four dot-rate and character-width combinations then completes several whole lines within a few hundred clocks. At these sizes every line boundary, the shift into blanking, and both address cadences can be checked cycle by cycle across consecutive lines. Mid-line writes and a mid-line frame restart show that configuration is captured only at a line start.

// File: rtl/char_htiming_pkg.sv
package char_htiming_pkg;

    localparam int DOTS_NARROW = 8;
    localparam int DOTS_WIDE   = 9;
    localparam int DOT_IDX_W   = $clog2(DOTS_WIDE);

    // Index of the final dot inside a character for the chosen width
    function automatic logic [DOT_IDX_W-1:0] last_dot(input logic wide);
        return wide ? DOT_IDX_W'(DOTS_WIDE - 1) : DOT_IDX_W'(DOTS_NARROW - 1);
    endfunction

endpackage

// File: rtl/char_htiming_clkgen.sv
module char_htiming_clkgen
    import char_htiming_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic half_rate,
    input  logic nine_dot,
    output logic dot_en,
    output logic char_en,
    output logic first_dot,
    output logic pad_dot
);

    typedef struct packed {
        logic                 phase;
        logic [DOT_IDX_W-1:0] idx;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic [DOT_IDX_W-1:0] last_idx;

    always_comb begin
        last_idx  = last_dot(nine_dot);
        dot_en    = ~half_rate | ~st_q.phase;
        char_en   = dot_en && (st_q.idx == last_idx);
        first_dot = (st_q.idx == '0);
        pad_dot   = nine_dot && (st_q.idx == DOT_IDX_W'(DOTS_WIDE - 1));

        st_d       = st_q;
        st_d.phase = half_rate ? ~st_q.phase : 1'b0;
        if (dot_en) begin
            st_d.idx = (st_q.idx == last_idx) ? '0 : st_q.idx + 1'b1;
        end
        if (frame_start) begin
            st_d.phase = 1'b0;
            st_d.idx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-rate dot enables never fall on adjacent master clocks
    assert_dot_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && dot_en && !frame_start) |=> (!dot_en || !half_rate))
        else $error("dot enable adjacent in half-rate mode");

    // In 8-dot mode the dot index never reaches the ninth position
    assert_dot_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nine_dot |-> (st_q.idx <= DOT_IDX_W'(DOTS_NARROW - 1)))
        else $error("dot index beyond 8-dot character");

endmodule

// File: rtl/char_htiming_hcount.sv
module char_htiming_hcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             char_en,
    input  logic [CNT_W-1:0] disp_end,
    input  logic [CNT_W-1:0] total,
    output logic             disp_en,
    output logic             at_head,
    output logic             line_wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] hc;
    } hc_st_t;

    hc_st_t st_d, st_q;

    always_comb begin
        disp_en   = (st_q.hc <= disp_end);
        at_head   = (st_q.hc == '0);
        line_wrap = char_en && (st_q.hc == total);

        st_d = st_q;
        if (char_en) begin
            st_d.hc = line_wrap ? '0 : st_q.hc + 1'b1;
        end
        if (frame_start) begin
            st_d.hc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_hc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hc <= total)
        else $error("character counter beyond total");

    assert_wrap_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_wrap |=> at_head)
        else $error("counter did not return to zero after wrap");

endmodule

// File: rtl/char_htiming_addr.sv
module char_htiming_addr #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              line_wrap,
    input  logic              char_en,
    input  logic              disp_en,
    input  logic              half_step,
    input  logic [OFS_W-1:0]  line_step,
    output logic [ADDR_W-1:0] mem_addr
);

    typedef struct packed {
        logic              aphase;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
    } addr_st_t;

    addr_st_t st_d, st_q;
    logic [ADDR_W-1:0] next_base;

    always_comb begin
        mem_addr  = st_q.addr;
        next_base = st_q.base + ADDR_W'(line_step);

        st_d = st_q;
        if (char_en && disp_en) begin
            if (!half_step || st_q.aphase) begin
                st_d.addr = st_q.addr + 1'b1;
            end
            st_d.aphase = half_step ? ~st_q.aphase : 1'b0;
        end
        if (line_wrap) begin
            st_d.base   = next_base;
            st_d.addr   = next_base;
            st_d.aphase = 1'b0;
        end
        if (frame_start) begin
            st_d.base   = start_addr;
            st_d.addr   = start_addr;
            st_d.aphase = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{aphase: 1'b0, addr: start_addr, base: start_addr};
        end else begin
            st_q <= st_d;
        end
    end

    // Within a line the address only holds or steps by one
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_wrap && !frame_start) |=>
            ((st_q.addr == $past(st_q.addr)) || (st_q.addr == ADDR_W'($past(st_q.addr) + 1'b1))))
        else $error("address jumped within a line");

    assert_blank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_en && !line_wrap && !frame_start) |=> $stable(st_q.addr))
        else $error("address moved during blanking");

    assert_half_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_step && char_en && disp_en && !st_q.aphase && !line_wrap && !frame_start)
            |=> $stable(st_q.addr))
        else $error("address advanced on even character in half-step mode");

endmodule

// File: rtl/char_htiming.sv
module char_htiming
    import char_htiming_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cfg_dot_half,
    input  logic              cfg_nine_dot,
    input  logic [CNT_W-1:0]  cfg_disp_end,
    input  logic [CNT_W-1:0]  cfg_total,
    input  logic              cfg_addr_half,
    input  logic [OFS_W-1:0]  cfg_line_step,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    output logic              dot_en,
    output logic              char_en,
    output logic              disp_en,
    output logic              line_start,
    output logic              pad_dot,
    output logic [ADDR_W-1:0] mem_addr
);

    typedef struct packed {
        logic             half_rate;
        logic             nine;
        logic [CNT_W-1:0] disp_end;
        logic [CNT_W-1:0] total;
        logic             addr_half;
        logic [OFS_W-1:0] step;
    } cfg_t;

    cfg_t cfg_in, cfg_d, cfg_q;
    logic first_dot;
    logic at_head;
    logic line_wrap;

    // Shadow copy of the configuration, refreshed only at a line start
    always_comb begin
        cfg_in = '{half_rate: cfg_dot_half, nine: cfg_nine_dot,
                   disp_end: cfg_disp_end, total: cfg_total,
                   addr_half: cfg_addr_half, step: cfg_line_step};
        cfg_d  = (line_wrap || frame_start) ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_in;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    char_htiming_clkgen u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .half_rate   (cfg_q.half_rate),
        .nine_dot    (cfg_q.nine),
        .dot_en      (dot_en),
        .char_en     (char_en),
        .first_dot   (first_dot),
        .pad_dot     (pad_dot)
    );

    char_htiming_hcount #(.CNT_W(CNT_W)) u_hcount (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .char_en     (char_en),
        .disp_end    (cfg_q.disp_end),
        .total       (cfg_q.total),
        .disp_en     (disp_en),
        .at_head     (at_head),
        .line_wrap   (line_wrap)
    );

    char_htiming_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .start_addr  (cfg_start_addr),
        .line_wrap   (line_wrap),
        .char_en     (char_en),
        .disp_en     (disp_en),
        .half_step   (cfg_q.addr_half),
        .line_step   (cfg_q.step),
        .mem_addr    (mem_addr)
    );

    always_comb begin
        line_start = dot_en && first_dot && at_head;
    end

    assert_ls_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start) |=> !line_start)
        else $error("line start longer than one clock");

    assert_frame_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_start && disp_en))
        else $error("frame start did not open a new line");

endmodule

// File: tb/char_htiming_tb.sv
module char_htiming_tb_top;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 16;
    localparam int OFS_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              cfg_dot_half = 1'b0;
    logic              cfg_nine_dot = 1'b0;
    logic [CNT_W-1:0]  cfg_disp_end = '0;
    logic [CNT_W-1:0]  cfg_total = '0;
    logic              cfg_addr_half = 1'b0;
    logic [OFS_W-1:0]  cfg_line_step = '0;
    logic [ADDR_W-1:0] cfg_start_addr = '0;
    logic              dot_en, char_en, disp_en, line_start, pad_dot;
    logic [ADDR_W-1:0] mem_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    char_htiming #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_dot_half(cfg_dot_half), .cfg_nine_dot(cfg_nine_dot),
        .cfg_disp_end(cfg_disp_end), .cfg_total(cfg_total),
        .cfg_addr_half(cfg_addr_half), .cfg_line_step(cfg_line_step),
        .cfg_start_addr(cfg_start_addr),
        .dot_en(dot_en), .char_en(char_en), .disp_en(disp_en),
        .line_start(line_start), .pad_dot(pad_dot), .mem_addr(mem_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic set_cfg(input int div, input int nine, input int hde, input int htot,
                           input int adiv, input int ofs, input int start);
        cfg_dot_half   = div[0];
        cfg_nine_dot   = nine[0];
        cfg_disp_end   = CNT_W'(hde);
        cfg_total      = CNT_W'(htot);
        cfg_addr_half  = adiv[0];
        cfg_line_step  = OFS_W'(ofs);
        cfg_start_addr = ADDR_W'(start);
    endtask

    // Called on a negedge; leaves on the negedge where the new line begins
    task automatic frame_restart(input int start);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check(line_start === 1'b1, "R10 line_start", int'(line_start), 1);
        check(int'(mem_addr) == start, "R10 start address", int'(mem_addr), start);
    endtask

    // Measures one whole line starting at the current line_start negedge
    task automatic run_line(input int div, input int nine, input int hde, input int htot,
                            input int adiv, input int base, input int chg_cyc,
                            input int chg_hde, input int chg_ofs);
        int dpc, per, cyc, den, nchar, ndot, npad, abad, bad_act, bad_exp;
        dpc = nine ? 9 : 8;
        per = dpc * (div ? 2 : 1);
        cyc = 0; den = 0; nchar = 0; ndot = 0; npad = 0; abad = 0;
        bad_act = 0; bad_exp = 0;
        check(int'(mem_addr) == (base & 16'hFFFF), "R8 line first address",
              int'(mem_addr), base & 16'hFFFF);
        do begin
            if (cyc == chg_cyc) begin
                cfg_disp_end  = CNT_W'(chg_hde);
                cfg_line_step = OFS_W'(chg_ofs);
            end
            if (disp_en) den++;
            if (dot_en) ndot++;
            if (dot_en && pad_dot) npad++;
            if (char_en) begin
                int k, e;
                k = imin(nchar, hde + 1);
                e = (base + (adiv ? k / 2 : k)) & 16'hFFFF;
                if (int'(mem_addr) != e) begin
                    abad++;
                    bad_act = int'(mem_addr);
                    bad_exp = e;
                end
                nchar++;
            end
            cyc++;
            @(negedge clk);
        end while (!line_start && cyc < 5000);
        check(cyc == (htot + 1) * per, "R4 line length", cyc, (htot + 1) * per);
        check(den == (hde + 1) * per, "R3 display enable length", den, (hde + 1) * per);
        check(nchar == htot + 1, "R2 characters per line", nchar, htot + 1);
        check(ndot == (htot + 1) * dpc, "R1 dots per line", ndot, (htot + 1) * dpc);
        check(npad == (nine ? htot + 1 : 0), "R9 filler dots", npad, nine ? htot + 1 : 0);
        if (adiv) check(abad == 0, "R7 half-step address", bad_act, bad_exp);
        else      check(abad == 0, "R6 address per character", bad_act, bad_exp);
    endtask

    task automatic t_reset();
        set_cfg(0, 0, 5, 9, 0, 20, 100);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(mem_addr) == 100, "R12 reset address", int'(mem_addr), 100);
        check(line_start === 1'b1, "R12 reset line_start", int'(line_start), 1);
        check(disp_en === 1'b1, "R12 reset disp_en", int'(disp_en), 1);
        check(char_en === 1'b0, "R12 reset char_en", int'(char_en), 0);
        rst_n = 1'b1;
        run_line(0, 0, 5, 9, 0, 100, -1, 0, 0);
        run_line(0, 0, 5, 9, 0, 120, -1, 0, 0);
    endtask

    task automatic t_cadence(input int div, input int nine);
        set_cfg(div, nine, 6, 10, 0, 33, 500);
        frame_restart(500);
        run_line(div, nine, 6, 10, 0, 500, -1, 0, 0);
        run_line(div, nine, 6, 10, 0, 533, -1, 0, 0);
    endtask

    task automatic t_addr(input int adiv);
        set_cfg(0, 1, 7, 11, adiv, 40, 16'hFFB0);
        frame_restart(16'hFFB0);
        run_line(0, 1, 7, 11, adiv, 16'hFFB0, -1, 0, 0);
        run_line(0, 1, 7, 11, adiv, 16'hFFB0 + 40, -1, 0, 0);
        run_line(0, 1, 7, 11, adiv, 16'hFFB0 + 80, -1, 0, 0);
    endtask

    // R11: mid-line writes apply from the next line
    task automatic t_midline();
        set_cfg(0, 0, 5, 9, 0, 10, 200);
        frame_restart(200);
        run_line(0, 0, 5, 9, 0, 200, 12, 2, 50);
        run_line(0, 0, 2, 9, 0, 210, -1, 0, 0);
        run_line(0, 0, 2, 9, 0, 260, -1, 0, 0);
    endtask

    task automatic t_frame_mid();
        set_cfg(1, 0, 4, 9, 0, 8, 64);
        frame_restart(64);
        repeat (37) @(negedge clk);
        set_cfg(0, 1, 3, 9, 1, 8, 768);
        frame_restart(768);
        run_line(0, 1, 3, 9, 1, 768, -1, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cadence(0, 0);
        t_cadence(0, 1);
        t_cadence(1, 0);
        t_cadence(1, 1);
        t_addr(0);
        t_addr(1);
        t_midline();
        t_frame_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule